// File: doc/BRIEF.md
# Integrating Converter Rundown Sequencer

After the run-up of a multislope integrating converter, the integrator holds a leftover charge of either sign. This block removes that charge and measures it by timing it against the reference switches. A start pulse begins the sequence. The negative reference switch closes at once, without reading the comparator, and stays closed until the comparator reports a positive integrator. After a short settling gap with both switches open, the positive reference switch closes until the comparator reports a negative integrator again. Both switches then open and the integrator holds its value. After a programmable hold time the block pulses a trigger for the residue ADC conversion.

The switching order is always negative, gap, positive, open. Only the lengths of the two phases change from one conversion to the next. Each phase is stretched to a minimum length so that the integrator can settle. For each conversion the block pushes three words on a strobe-only output channel: the run-up count supplied with the start pulse, the negative-phase clock count, and the running total of the negative and positive phase counts. With ideal reference symmetry the host forms the rundown term from these words as a constant, minus twice the second word, plus the third. If a phase never ends, a timeout opens both switches and raises an error flag.

States: `ST_IDLE` goes to `ST_NEG` on start. `ST_NEG` goes to `ST_GAP` on the exit condition and to `ST_IDLE` on timeout. `ST_GAP` goes to `ST_POS` after the gap. `ST_POS` goes to `ST_HOLD` on the exit condition and to `ST_IDLE` on timeout. `ST_HOLD` goes to `ST_TRIG` when the hold time has elapsed. `ST_TRIG` always goes to `ST_IDLE`.

Top module: `rundown_seq`

## Requirements
- R1: After reset, ref_pos, ref_neg, out_valid, adc_trig, busy and sat_err are all 0.
- R2: In the cycle after start is sampled high in the idle state, ref_neg is 1 and ref_pos is 0, whatever the value of cmp_pos. The run-up word (runup_count, forwarded unchanged) is pushed in that same cycle.
- R3: ref_neg stays high for N = max(MIN_PH, k) cycles, where k is the first negative-phase cycle (counted from 1) at whose end cmp_pos is 1. The second word is N in output form.
- R4: Between the negative and positive phases both switches are open for exactly GAP_LEN cycles.
- R5: ref_pos stays high for P = max(MIN_PH, j) cycles, where j is the first positive-phase cycle at whose end cmp_pos is 0. The third word is N+P in output form.
- R6: A completed conversion pushes exactly three words, one per out_valid cycle: run-up word, negative count, cumulative count. Output form: with INVERT_OUT=1 a count c is pushed as ~c (CW bits); with INVERT_OUT=0 it is pushed as c.
- R7: ref_pos and ref_neg are never high together. Both are low from the end of the positive phase onward, and both are low during the trigger.
- R8: adc_trig is high for exactly one cycle, hold_cycles+1 cycles after the cycle that carries the third word. The block is idle in the following cycle.
- R9: If a phase reaches TMO cycles without its exit condition, both switches open, sat_err rises, no further word is pushed and no trigger occurs. sat_err stays high until the next accepted start clears it.
- R10: A start pulse while busy is ignored and does not change the words or the phase timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a rundown (accepted only when idle) |
| runup_count | input | CW | Run-up count, forwarded as the first word |
| hold_cycles | input | HW | Hold time before the residue trigger, sampled at start |
| cmp_pos | input | 1 | Synchronized comparator, 1 = integrator positive |
| ref_pos | output | 1 | Positive reference switch |
| ref_neg | output | 1 | Negative reference switch |
| out_valid | output | 1 | Word push strobe |
| out_data | output | CW | Pushed word |
| adc_trig | output | 1 | Residue ADC trigger pulse |
| busy | output | 1 | Sequence in progress |
| sat_err | output | 1 | Phase timeout occurred |

## Verification
The assertions assume that cmp_pos is already synchronized to clk and that MIN_PH is no larger than TMO. They also assume that start may arrive in any state. The bench follows these assumptions: it drives cmp_pos only on falling edges, from a comparator model that flips a chosen number of cycles into each phase. It also pulses start in the middle of a sequence. Random flip points, including flips before the minimum length and flips beyond the timeout, exercise every phase exit.

// File: rtl/rundown_pkg.sv
package rundown_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_NEG  = 3'd1,
        ST_GAP  = 3'd2,
        ST_POS  = 3'd3,
        ST_HOLD = 3'd4,
        ST_TRIG = 3'd5
    } rd_state_e;

endpackage

// File: rtl/rd_phase_ctr.sv
module rd_phase_ctr #(
    parameter int MIN_PH = 4,
    parameter int TMO    = 4096,
    localparam int PW    = $clog2(TMO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic at_min,
    output logic at_tmo
);
    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (!rst_n)   ph <= '0;
        else if (clr) ph <= PW'(1);
        else if (en)  ph <= ph + PW'(1);
    end

    assign at_min = (ph >= PW'(MIN_PH));
    assign at_tmo = (ph == PW'(TMO));
endmodule

// File: rtl/rd_total_ctr.sv
module rd_total_ctr #(
    parameter int CW         = 24,
    parameter bit INVERT_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] word
);
    logic [CW-1:0] tot;

    always_ff @(posedge clk) begin
        if (!rst_n)    tot <= '0;
        else if (clr)  tot <= CW'(1);
        else if (inc)  tot <= tot + CW'(1);
    end

    generate
        if (INVERT_OUT) begin : g_down
            assign word = ~tot;
        end else begin : g_up
            assign word = tot;
        end
    endgenerate
endmodule

// File: rtl/rd_delay_ctr.sv
module rd_delay_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] limit,
    output logic          done
);
    logic [DW-1:0] d;

    always_ff @(posedge clk) begin
        if (!rst_n)   d <= '0;
        else if (clr) d <= '0;
        else if (en)  d <= d + DW'(1);
    end

    assign done = (d >= limit);
endmodule

// File: rtl/rundown_seq.sv
module rundown_seq
    import rundown_pkg::*;
#(
    parameter int CW         = 24,
    parameter int HW         = 8,
    parameter int MIN_PH     = 4,
    parameter int GAP_LEN    = 3,
    parameter int TMO        = 4096,
    parameter bit INVERT_OUT = 1'b1,
    localparam int GW        = $clog2(GAP_LEN + 1),
    localparam int DW        = (HW > GW) ? HW : GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] runup_count,
    input  logic [HW-1:0] hold_cycles,
    input  logic          cmp_pos,
    output logic          ref_pos,
    output logic          ref_neg,
    output logic          out_valid,
    output logic [CW-1:0] out_data,
    output logic          adc_trig,
    output logic          busy,
    output logic          sat_err
);
    rd_state_e state, nxt;

    logic ph_clr, ph_en, at_min, at_tmo;
    logic tot_clr, tot_inc;
    logic d_clr, d_en, d_done;
    logic push, push_ru, err_set, accept;
    logic [CW-1:0] tot_word;
    logic [HW-1:0] hold_q;
    logic [DW-1:0] d_limit;

    rd_phase_ctr #(.MIN_PH(MIN_PH), .TMO(TMO)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(ph_en),
        .at_min(at_min), .at_tmo(at_tmo)
    );

    rd_total_ctr #(.CW(CW), .INVERT_OUT(INVERT_OUT)) u_total (
        .clk(clk), .rst_n(rst_n), .clr(tot_clr), .inc(tot_inc),
        .word(tot_word)
    );

    assign d_limit = (state == ST_GAP) ? DW'(GAP_LEN - 1) : DW'(hold_q);

    rd_delay_ctr #(.DW(DW)) u_delay (
        .clk(clk), .rst_n(rst_n), .clr(d_clr), .en(d_en),
        .limit(d_limit), .done(d_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and counter controls
    always_comb begin
        nxt     = state;
        ph_clr  = 1'b0;
        ph_en   = 1'b0;
        tot_clr = 1'b0;
        tot_inc = 1'b0;
        d_clr   = 1'b0;
        d_en    = 1'b0;
        push    = 1'b0;
        push_ru = 1'b0;
        err_set = 1'b0;
        accept  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt     = ST_NEG;
                    accept  = 1'b1;
                    ph_clr  = 1'b1;
                    tot_clr = 1'b1;
                    push    = 1'b1;
                    push_ru = 1'b1;
                end
            end
            ST_NEG: begin
                if (cmp_pos && at_min) begin
                    nxt   = ST_GAP;
                    d_clr = 1'b1;
                    push  = 1'b1;
                end else if (at_tmo) begin
                    nxt     = ST_IDLE;
                    err_set = 1'b1;
                end else begin
                    ph_en   = 1'b1;
                    tot_inc = 1'b1;
                end
            end
            ST_GAP: begin
                if (d_done) begin
                    nxt     = ST_POS;
                    ph_clr  = 1'b1;
                    tot_inc = 1'b1;
                end else begin
                    d_en = 1'b1;
                end
            end
            ST_POS: begin
                if (!cmp_pos && at_min) begin
                    nxt   = ST_HOLD;
                    d_clr = 1'b1;
                    push  = 1'b1;
                end else if (at_tmo) begin
                    nxt     = ST_IDLE;
                    err_set = 1'b1;
                end else begin
                    ph_en   = 1'b1;
                    tot_inc = 1'b1;
                end
            end
            ST_HOLD: begin
                if (d_done) nxt = ST_TRIG;
                else        d_en = 1'b1;
            end
            ST_TRIG: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            sat_err   <= 1'b0;
            hold_q    <= '0;
        end else begin
            out_valid <= push;
            if (push) out_data <= push_ru ? runup_count : tot_word;
            if (accept) begin
                sat_err <= 1'b0;
                hold_q  <= hold_cycles;
            end else if (err_set) begin
                sat_err <= 1'b1;
            end
        end
    end

    assign ref_neg  = (state == ST_NEG);
    assign ref_pos  = (state == ST_POS);
    assign adc_trig = (state == ST_TRIG);
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/rundown_chk.sv
module rundown_chk #(
    parameter int MIN_PH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic ref_pos,
    input logic ref_neg,
    input logic out_valid,
    input logic adc_trig,
    input logic sat_err
);
    logic [15:0] neg_run, pos_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_run <= '0;
            pos_run <= '0;
        end else begin
            neg_run <= ref_neg ? neg_run + 16'd1 : 16'd0;
            pos_run <= ref_pos ? pos_run + 16'd1 : 16'd0;
        end
    end

    AST_REF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_pos && ref_neg)); // R7
    AST_NEG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (ref_neg && !ref_pos && out_valid)); // R2
    AST_NEG_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_neg) && !sat_err) |-> (neg_run >= 16'(MIN_PH))); // R3
    AST_POS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_pos) && !sat_err) |-> (pos_run >= 16'(MIN_PH))); // R5
    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> (!adc_trig && !busy)); // R8
    AST_TRIG_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (!ref_pos && !ref_neg)); // R7
    AST_ERR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        sat_err |-> (!ref_pos && !ref_neg && !adc_trig)); // R9
endmodule

bind rundown_seq rundown_chk #(.MIN_PH(MIN_PH)) u_rundown_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .ref_pos(ref_pos), .ref_neg(ref_neg), .out_valid(out_valid),
    .adc_trig(adc_trig), .sat_err(sat_err)
);

// File: tb/test_rundown_seq.sv
module test_rundown_seq;
    localparam int CW = 16, HW = 8, MINP = 4, GAP = 3, TMO = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, start, cmp_pos;
    logic [CW-1:0] runup_count, out_data;
    logic [HW-1:0] hold_cycles;
    logic ref_pos, ref_neg, out_valid, adc_trig, busy, sat_err;

    rundown_seq #(.CW(CW), .HW(HW), .MIN_PH(MINP), .GAP_LEN(GAP), .TMO(TMO),
                  .INVERT_OUT(1'b1)) i_rundown_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .runup_count(runup_count),
        .hold_cycles(hold_cycles), .cmp_pos(cmp_pos), .ref_pos(ref_pos),
        .ref_neg(ref_neg), .out_valid(out_valid), .out_data(out_data),
        .adc_trig(adc_trig), .busy(busy), .sat_err(sat_err)
    );

    int nvec = 0, nfail = 0, cyc = 0;
    int n1, n2, nneg, npos, gapc, nw, ntrig, w3_cyc, trig_cyc;
    bit first_neg_ok;
    logic [CW-1:0] words [0:7];

    task automatic chk(bit ok, string req, longint act, longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int elen(int k);
        return (k < MINP) ? MINP : k;
    endfunction

    function automatic logic [CW-1:0] fmtw(int c);
        return ~CW'(c);
    endfunction

    // monitor and comparator model
    always @(negedge clk) begin
        cyc++;
        if (out_valid) begin
            if (nw < 8) words[nw] = out_data;
            nw++;
            if (nw == 1) first_neg_ok = ref_neg && !ref_pos;
            if (nw == 3) w3_cyc = cyc;
        end
        if (ref_neg) begin
            nneg++;
            cmp_pos = (nneg >= n1);
        end else if (ref_pos) begin
            npos++;
            cmp_pos = !(npos >= n2);
        end
        if (busy && !ref_neg && !ref_pos && !adc_trig && nneg > 0 && npos == 0) gapc++;
        if (adc_trig) begin
            ntrig++;
            trig_cyc = cyc;
        end
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic run_conv(int a, int b, int h, bit again);
        int guard;
        bit tn, tp;
        int en, ep;
        logic [CW-1:0] rc;
        rc = CW'($urandom);
        nneg = 0; npos = 0; gapc = 0; nw = 0; ntrig = 0; w3_cyc = 0; trig_cyc = 0;
        first_neg_ok = 1'b0;
        n1 = a; n2 = b;
        hold_cycles = HW'(h);
        runup_count = rc;
        cmp_pos = 1'($urandom);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (again) begin
            repeat (2) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(guard < 2000, "watchdog", guard, 0);
        tn = (a > TMO);
        tp = !tn && (b > TMO);
        en = elen(a);
        ep = elen(b);
        chk(first_neg_ok, "R2 neg first", first_neg_ok, 1);
        chk(words[0] == rc, "R6 runup word", words[0], rc);
        if (tn) begin
            chk(nw == 1, "R9 words after neg timeout", nw, 1);
            chk(nneg == TMO, "R9 neg timeout length", nneg, TMO);
        end else begin
            chk(nneg == en, "R3 neg length", nneg, en);
            chk(words[1] == fmtw(en), "R3 neg word", words[1], fmtw(en));
            chk(gapc == GAP, "R4 gap length", gapc, GAP);
        end
        if (tp) begin
            chk(nw == 2, "R9 words after pos timeout", nw, 2);
            chk(npos == TMO, "R9 pos timeout length", npos, TMO);
        end
        if (tn || tp) begin
            chk(sat_err == 1'b1, "R9 sat_err set", sat_err, 1);
            chk(ntrig == 0, "R9 no trigger", ntrig, 0);
        end else begin
            chk(nw == 3, again ? "R10 words with second start" : "R6 word count", nw, 3);
            chk(npos == ep, "R5 pos length", npos, ep);
            chk(words[2] == fmtw(en + ep), "R5 cumulative word", words[2], fmtw(en + ep));
            chk(ntrig == 1, "R8 one trigger", ntrig, 1);
            chk(trig_cyc - w3_cyc == h + 1, "R8 trigger delay", trig_cyc - w3_cyc, h + 1);
            chk(sat_err == 1'b0, "R9 sat_err clear", sat_err, 0);
        end
        chk(!ref_pos && !ref_neg, "R7 switches open at end", {ref_pos, ref_neg}, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; cmp_pos = 1'b0;
        runup_count = '0; hold_cycles = '0;
        n1 = 1; n2 = 1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ref_pos, ref_neg, out_valid, adc_trig, busy, sat_err} == 6'b0,
            "R1 reset state", {ref_pos, ref_neg, out_valid, adc_trig, busy, sat_err}, 0);
        run_conv(1, 1, 0, 1'b0);       // both phases at minimum
        run_conv(MINP, MINP, 2, 1'b0);
        run_conv(MINP + 1, 2, 3, 1'b0);
        run_conv(2, 11, 0, 1'b0);
        run_conv(7, 5, 4, 1'b1);       // R10 extra start mid-sequence
        run_conv(TMO, 3, 1, 1'b0);     // exits on the timeout cycle itself
        for (int i = 0; i < 24; i++)
            run_conv(1 + int'($urandom_range(0, 20)), 1 + int'($urandom_range(0, 20)),
                     int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        run_conv(200, 3, 1, 1'b0);     // R9 neg timeout
        run_conv(3, 3, 1, 1'b0);       // R9 clears on next start
        run_conv(5, 300, 1, 1'b0);     // R9 pos timeout
        run_conv(9, 9, 5, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule